// File: doc/BRIEF.md
# Latch-Style Dual-Read Register File

This block is a 32-entry, 32-bit register file with two read outputs and a single write path. Its clock is level-sensitive rather than edge-triggered. While the clock is high the file is transparent. A read then passes the addressed contents straight to the outputs. A write passes the data input straight into the addressed entry. While the clock is low every entry and both outputs hold their values, whatever the other inputs do.

The whole access is either a read or a write, chosen by one mode bit. There is no separate write enable. The first address input serves as the read address for output A and also as the destination of a write. The second address only drives output B.

Entry 0 is fixed at zero. An asynchronous active-low reset clears all entries and both outputs.

Internally the clock level and the mode bit are decoded into one of three access phases. These are named in the RTL as `PH_HOLD` (clock low), `PH_READ` (clock high, mode 1) and `PH_WRITE` (clock high, mode 0). The phase changes combinationally and follows its inputs directly. PH_HOLD goes to PH_READ or PH_WRITE when the clock rises, depending on the mode bit. Either of those returns to PH_HOLD when the clock falls. The RTL also has a transition between PH_READ and PH_WRITE when the mode bit changes while the clock is high, but the bench never drives it.

Top module: `latch_regfile`

## Requirements
- R1: With `clk` high and `rd_nwr` = 1, `rd_a` shows the entry addressed by `addr_a` and `rd_b` shows the entry addressed by `addr_b`. Either output follows an address change made during the high phase, with no clock edge needed.
- R2: `rd_nwr` = 1 selects a read and `rd_nwr` = 0 selects a write.
- R3: During a write with `clk` high, the entry addressed by `addr_a` takes the value on `wr_data`. `addr_b` has no effect on which entry is written.
- R4: During the high phase the file reacts to any input change. A `wr_data` change made mid-phase is what the entry holds once the clock falls.
- R5: While `clk` is low, both outputs and all entries hold their values. Changes to the addresses, the mode bit or the data have no effect.
- R6: During a write with `clk` high, `rd_a` and `rd_b` keep the values they last showed.
- R7: Entry 0 always reads as zero, and a write to address 0 is discarded.
- R8: When `rst_n` is 0, all entries and both outputs go to zero at once, independent of `clk`.
- R9: A read with `addr_a` equal to `addr_b` gives the same value on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Level-sensitive access clock: high is transparent, low holds |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_nwr | input | 1 | Access mode: 1 is read, 0 is write |
| addr_a | input | 5 | Address for output A, and the write destination |
| addr_b | input | 5 | Address for output B |
| wr_data | input | 32 | Value to write |
| rd_a | output | 32 | Read value for address A |
| rd_b | output | 32 | Read value for address B |

## Verification
The assertions sample the outputs on the falling clock edge, when the value from the high phase has settled. They also sample on the rising edge, when the value held through the low phase is visible.

They assume that `rd_nwr` stays constant throughout each high phase. Without that, the check that outputs hold during a write would compare against a snapshot taken under a different mode. They also assume that reset is applied only while the clock is low.

The stimulus changes the mode bit only in the low phase and pulses reset only in the low phase. It does change addresses and data in the middle of high phases, because that transparency is behaviour the block has to show.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Access phase decoded from the clock level and the mode bit
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/rf_phase_decode.sv
module rf_phase_decode
    import rf_pkg::*;
(
    input  logic clk,
    input  logic rd_nwr,
    output logic rd_open,
    output logic wr_open
);

    phase_e phase;

    // Phase selection: follows clock level and mode with no storage
    always_comb begin
        unique case ({clk, rd_nwr})
            2'b11:   phase = PH_READ;
            2'b10:   phase = PH_WRITE;
            default: phase = PH_HOLD;
        endcase
    end

    // Phase outputs
    always_comb begin
        rd_open = 1'b0;
        wr_open = 1'b0;
        unique case (phase)
            PH_READ:  rd_open = 1'b1;
            PH_WRITE: wr_open = 1'b1;
            PH_HOLD:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
    parameter int WIDTH = 32
) (
    input  logic             rst_n,
    input  logic             open,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Transparent while open, holds otherwise, cleared asynchronously
    always_latch begin
        if (!rst_n)
            q <= '0;
        else if (open)
            q <= d;
    end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int WIDTH = 32,
    parameter int AW    = 5,
    localparam int DEPTH = 1 << AW
) (
    input  logic                        rst_n,
    input  logic                        wr_open,
    input  logic [AW-1:0]               wr_addr,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0] entries
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign entries[i] = '0;
        end else begin : g_cell
            logic sel;
            assign sel = wr_open && (wr_addr == AW'(i));
            rf_cell #(.WIDTH(WIDTH)) i_cell (
                .rst_n (rst_n),
                .open  (sel),
                .d     (wr_data),
                .q     (entries[i])
            );
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int WIDTH = 32,
    parameter int AW    = 5,
    localparam int DEPTH = 1 << AW
) (
    input  logic                        rst_n,
    input  logic                        rd_open,
    input  logic [DEPTH-1:0][WIDTH-1:0] entries,
    input  logic [AW-1:0]               addr,
    output logic [WIDTH-1:0]            q
);

    logic [WIDTH-1:0] picked;

    assign picked = entries[addr];

    // Output latch: follows the selection during a read, holds otherwise
    rf_cell #(.WIDTH(WIDTH)) i_out (
        .rst_n (rst_n),
        .open  (rd_open),
        .d     (picked),
        .q     (q)
    );

endmodule

// File: rtl/latch_regfile.sv
module latch_regfile #(
    parameter int WIDTH = 32,
    parameter int AW    = 5,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_nwr,
    input  logic [AW-1:0]    addr_a,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);

    logic                        rd_open;
    logic                        wr_open;
    logic [DEPTH-1:0][WIDTH-1:0] entries;

    rf_phase_decode i_phase (
        .clk     (clk),
        .rd_nwr  (rd_nwr),
        .rd_open (rd_open),
        .wr_open (wr_open)
    );

    rf_bank #(.WIDTH(WIDTH), .AW(AW)) i_bank (
        .rst_n   (rst_n),
        .wr_open (wr_open),
        .wr_addr (addr_a),
        .wr_data (wr_data),
        .entries (entries)
    );

    rf_read_port #(.WIDTH(WIDTH), .AW(AW)) i_port_a (
        .rst_n   (rst_n),
        .rd_open (rd_open),
        .entries (entries),
        .addr    (addr_a),
        .q       (rd_a)
    );

    rf_read_port #(.WIDTH(WIDTH), .AW(AW)) i_port_b (
        .rst_n   (rst_n),
        .rd_open (rd_open),
        .entries (entries),
        .addr    (addr_b),
        .q       (rd_b)
    );

endmodule

// File: rtl/latch_regfile_chk.sv
module latch_regfile_chk #(
    parameter int WIDTH = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_nwr,
    input logic [AW-1:0]    addr_a,
    input logic [AW-1:0]    addr_b,
    input logic [WIDTH-1:0] rd_a,
    input logic [WIDTH-1:0] rd_b
);

    logic [WIDTH-1:0] lo_a, lo_b, hi_a, hi_b;
    logic             lo_valid, hi_valid;

    // Output values captured as the clock falls
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_a     <= '0;
            lo_b     <= '0;
            lo_valid <= 1'b0;
        end else begin
            lo_a     <= rd_a;
            lo_b     <= rd_b;
            lo_valid <= 1'b1;
        end
    end

    // Output values captured as the clock rises
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_a     <= '0;
            hi_b     <= '0;
            hi_valid <= 1'b0;
        end else begin
            hi_a     <= rd_a;
            hi_b     <= rd_b;
            hi_valid <= 1'b1;
        end
    end

    // R5
    low_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |-> (rd_a == lo_a && rd_b == lo_b));

    // R6
    write_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (hi_valid && !rd_nwr) |-> (rd_a == hi_a && rd_b == hi_b));

    // R7
    zero_entry_a_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_nwr && addr_a == '0) |-> (rd_a == '0));

    // R7
    zero_entry_b_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_nwr && addr_b == '0) |-> (rd_b == '0));

    // R9
    same_addr_match_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_nwr && addr_a == addr_b) |-> (rd_a == rd_b));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |-> (rd_a == '0 && rd_b == '0));

endmodule

bind latch_regfile latch_regfile_chk #(.WIDTH(WIDTH), .AW(AW)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_nwr (rd_nwr),
    .addr_a (addr_a),
    .addr_b (addr_b),
    .rd_a   (rd_a),
    .rd_b   (rd_b)
);

// File: tb/test_latch_regfile.sv
`timescale 1ns/1ps
module test_latch_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_nwr = 1'b1;
    logic [4:0]  addr_a = '0;
    logic [4:0]  addr_b = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a, rd_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    latch_regfile i_latch_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_nwr  (rd_nwr),
        .addr_a  (addr_a),
        .addr_b  (addr_b),
        .wr_data (wr_data),
        .rd_a    (rd_a),
        .rd_b    (rd_b)
    );

    typedef struct packed {
        logic        mode;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [31:0] d;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 5'd1,  5'd2,  32'h11111111, 32'h00000000, 32'h00000000},
        '{1'b0, 5'd2,  5'd7,  32'h22222222, 32'h00000000, 32'h00000000},
        '{1'b1, 5'd1,  5'd2,  32'h0,        32'h11111111, 32'h22222222},
        '{1'b0, 5'd0,  5'd1,  32'hDEADBEEF, 32'h11111111, 32'h22222222},
        '{1'b1, 5'd0,  5'd1,  32'h0,        32'h00000000, 32'h11111111},
        '{1'b0, 5'd31, 5'd1,  32'hA5A5A5A5, 32'h00000000, 32'h11111111},
        '{1'b1, 5'd31, 5'd31, 32'h0,        32'hA5A5A5A5, 32'hA5A5A5A5},
        '{1'b0, 5'd1,  5'd31, 32'hCAFEF00D, 32'hA5A5A5A5, 32'hA5A5A5A5},
        '{1'b1, 5'd1,  5'd2,  32'h0,        32'hCAFEF00D, 32'h22222222},
        '{1'b1, 5'd2,  5'd31, 32'h0,        32'h22222222, 32'hA5A5A5A5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        #15;
        check("R8 reset rd_a", rd_a, 32'h0);
        check("R8 reset rd_b", rd_b, 32'h0);
        @(negedge clk);
        #2 rst_n = 1'b1;

        // R1 R2 R3 R6 R7 R9 vector walk; R5 hold checked after each fall
        for (int i = 0; i < NVEC; i++) begin
            rd_nwr  = VECS[i].mode;
            addr_a  = VECS[i].a;
            addr_b  = VECS[i].b;
            wr_data = VECS[i].d;
            @(posedge clk);
            #5;
            check(VECS[i].mode ? "R1/R2/R7/R9 read rd_a" : "R6 write hold rd_a", rd_a, VECS[i].exp_a);
            check(VECS[i].mode ? "R1/R3/R9 read rd_b" : "R6 write hold rd_b", rd_b, VECS[i].exp_b);
            @(negedge clk);
            #5;
            check("R5 low hold rd_a", rd_a, VECS[i].exp_a);
            check("R5 low hold rd_b", rd_b, VECS[i].exp_b);
        end

        // R4: data changed mid-phase of a write is what gets kept
        rd_nwr  = 1'b0;
        addr_a  = 5'd3;
        addr_b  = 5'd3;
        wr_data = 32'h00000001;
        @(posedge clk);
        #3 wr_data = 32'h33333333;
        @(negedge clk);
        #5;
        check("R6 hold after write rd_a", rd_a, 32'h22222222);
        rd_nwr = 1'b1;
        @(posedge clk);
        #5;
        check("R4 last data kept", rd_a, 32'h33333333);
        check("R9 same address rd_b", rd_b, 32'h33333333);

        // R1: address change during high read is followed
        addr_a = 5'd1;
        #2;
        check("R1 follow address mid-phase", rd_a, 32'hCAFEF00D);

        // R5: address change during low phase has no effect
        @(negedge clk);
        #3 addr_a = 5'd2;
        #2;
        check("R5 low address change ignored", rd_a, 32'hCAFEF00D);

        // R8: asynchronous reset in low phase
        #1 rst_n = 1'b0;
        #1;
        check("R8 async reset rd_a", rd_a, 32'h0);
        check("R8 async reset rd_b", rd_b, 32'h0);
        rst_n  = 1'b1;
        addr_b = 5'd1;
        @(posedge clk);
        #5;
        check("R8 entry 2 cleared", rd_a, 32'h0);
        check("R8 entry 1 cleared", rd_b, 32'h0);
        @(negedge clk);
        #5;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule